// File: doc/BRIEF.md
# Next-PC and Operand Address Generator

This block sits beside the fetch and decode stages of a 32-bit load-store processor with fixed 4-byte instructions. Each cycle it receives the address of the instruction being executed, the raw instruction word, one register operand and a taken/not-taken verdict from the condition logic elsewhere in the core. From these it forms the address of the next instruction to fetch, the return address for calls, the immediate operand in its signed or unsigned form, the constant for building the upper half of a word, and the effective address for loads and stores.

All outputs are purely combinational. Condition evaluation, the register file, the ALU and instruction memory belong to other blocks. A small control module decodes the opcode and function fields into a handful of strobes. A datapath module turns those strobes into addresses and operands.

Top module: `npc_addrgen`

## Requirements
- R1: `retAddr` always equals `curPc + 4`, and `nextPc` equals `curPc + 4` for every instruction not covered by R2, R3 or R4. This includes register-format words (opcode 0x00) whose function field (bits 5:0) is neither 0x08 nor 0x09.
- R2: For branch opcodes 0x04 to 0x07 (instruction bits 31:26) with `brTaken` high, `nextPc` equals `curPc + 4` plus the sign-extended 16-bit field (bits 15:0) shifted left by 2, taken modulo 2^32. With `brTaken` low the result is `curPc + 4`.
- R3: For jump opcodes 0x02 and 0x03, `nextPc` is built from bits 31:28 of `curPc + 4`, then instruction bits 25:0, then two zero bits.
- R4: For opcode 0x00 with function field 0x08 or 0x09, `nextPc` equals `regVal`.
- R5: `immOut` holds bits 15:0 zero-extended for opcodes 0x0C, 0x0D and 0x0E, and sign-extended for every other opcode.
- R6: `upperImm` holds instruction bits 15:0 in its upper half and zeros in its low 16 bits.
- R7: `memAddr` equals `regVal` plus the sign-extended bits 15:0, taken modulo 2^32, whatever the opcode.
- R8: `linkEn` is high only for opcode 0x03, and for opcode 0x00 with function field 0x09.
- R9: `brTaken` has no effect on any output unless the opcode is 0x04 to 0x07.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| curPc | input | 32 | Address of the current instruction |
| instrWord | input | 32 | Instruction word being executed |
| regVal | input | 32 | Register operand: base for displacement and target for indirect jumps |
| brTaken | input | 1 | Branch condition result from the condition logic |
| nextPc | output | 32 | Address of the next instruction to fetch |
| retAddr | output | 32 | Return address for link instructions |
| immOut | output | 32 | Extended 16-bit immediate |
| upperImm | output | 32 | Upper-immediate constant |
| memAddr | output | 32 | Base-plus-displacement memory address |
| linkEn | output | 1 | High when a return address must be written |

## Verification
The bench uses the default parameters: a 32-bit word, a 16-bit immediate and a 26-bit jump field. With these widths the jump splice keeps exactly four high bits of the incremented PC. Directed vectors cover the edge cases: a current PC of 0xFFFFFFFC, so that PC+4 wraps and the upper region changes before the jump splice; negative branch offsets and displacements that wrap below zero; and immediates with bit 15 set, which separate zero extension from sign extension. Random words drawn from every opcode group then exercise the mux priorities and confirm that `brTaken` is ignored outside the branch opcodes.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OP_JUMP    = 6'h02;
  localparam logic [OPC_W-1:0] OP_CALL    = 6'h03;
  localparam logic [OPC_W-1:0] OP_ANDI    = 6'h0C;
  localparam logic [OPC_W-1:0] OP_ORI     = 6'h0D;
  localparam logic [OPC_W-1:0] OP_XORI    = 6'h0E;
  localparam logic [FN_W-1:0]  FN_REGJMP  = 6'h08;
  localparam logic [FN_W-1:0]  FN_REGCALL = 6'h09;

  typedef struct packed {
    logic takeReg;
    logic takeJump;
    logic takeBranch;
    logic zeroExt;
    logic linkOn;
  } ctlStrobes_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             brTaken,
  output ctlStrobes_t      strobes
);
  logic isSpecial;
  logic isBranchOp;

  always_comb begin
    isSpecial  = (opcode == OP_SPECIAL);
    isBranchOp = (opcode[OPC_W-1:2] == 4'b0001);
    strobes.takeReg    = isSpecial && (funct == FN_REGJMP || funct == FN_REGCALL);
    strobes.takeJump   = (opcode == OP_JUMP) || (opcode == OP_CALL);
    strobes.takeBranch = isBranchOp && brTaken;
    strobes.zeroExt    = (opcode == OP_ANDI) || (opcode == OP_ORI) || (opcode == OP_XORI);
    strobes.linkOn     = (opcode == OP_CALL) || (isSpecial && funct == FN_REGCALL);
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int JFLD_W = 26
) (
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] regVal,
  input  ctlStrobes_t       strobes,
  output logic [DATA_W-1:0] nextPc,
  output logic [DATA_W-1:0] retAddr,
  output logic [DATA_W-1:0] immOut,
  output logic [DATA_W-1:0] upperImm,
  output logic [DATA_W-1:0] memAddr
);
  localparam int WORD_SHIFT = 2;
  localparam int INSTR_BYTES = 1 << WORD_SHIFT;
  localparam int EXT_W = DATA_W - IMM_W;
  localparam int REGION_W = DATA_W - JFLD_W - WORD_SHIFT;

  logic [IMM_W-1:0]  immField;
  logic [JFLD_W-1:0] jumpField;
  logic [DATA_W-1:0] pcPlus4;
  logic [DATA_W-1:0] immSigned;
  logic [DATA_W-1:0] immUnsigned;
  logic [DATA_W-1:0] branchTarget;
  logic [DATA_W-1:0] jumpTarget;

  always_comb begin
    immField     = instrWord[IMM_W-1:0];
    jumpField    = instrWord[JFLD_W-1:0];
    pcPlus4      = curPc + DATA_W'(INSTR_BYTES);
    immSigned    = {{EXT_W{immField[IMM_W-1]}}, immField};
    immUnsigned  = {{EXT_W{1'b0}}, immField};
    branchTarget = pcPlus4 + (immSigned << WORD_SHIFT);
    jumpTarget   = {pcPlus4[DATA_W-1 -: REGION_W], jumpField, {WORD_SHIFT{1'b0}}};

    if (strobes.takeReg)         nextPc = regVal;
    else if (strobes.takeJump)   nextPc = jumpTarget;
    else if (strobes.takeBranch) nextPc = branchTarget;
    else                         nextPc = pcPlus4;

    retAddr  = pcPlus4;
    immOut   = strobes.zeroExt ? immUnsigned : immSigned;
    upperImm = {immField, {EXT_W{1'b0}}};
    memAddr  = regVal + immSigned;
  end
endmodule

// File: rtl/npc_addrgen.sv
module npc_addrgen
  import npc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int JFLD_W = 26
) (
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] regVal,
  input  logic              brTaken,
  output logic [DATA_W-1:0] nextPc,
  output logic [DATA_W-1:0] retAddr,
  output logic [DATA_W-1:0] immOut,
  output logic [DATA_W-1:0] upperImm,
  output logic [DATA_W-1:0] memAddr,
  output logic              linkEn
);
  ctlStrobes_t strobes;

  npc_ctrl ctrl_i (
    .opcode  (instrWord[DATA_W-1 -: OPC_W]),
    .funct   (instrWord[FN_W-1:0]),
    .brTaken (brTaken),
    .strobes (strobes)
  );

  npc_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W), .JFLD_W(JFLD_W)) dp_i (
    .curPc     (curPc),
    .instrWord (instrWord),
    .regVal    (regVal),
    .strobes   (strobes),
    .nextPc    (nextPc),
    .retAddr   (retAddr),
    .immOut    (immOut),
    .upperImm  (upperImm),
    .memAddr   (memAddr)
  );

  assign linkEn = strobes.linkOn;
endmodule

// File: rtl/npc_addrgen_chk.sv
module npc_addrgen_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [DATA_W-1:0] curPc,
  input logic [DATA_W-1:0] instrWord,
  input logic [DATA_W-1:0] regVal,
  input logic              brTaken,
  input logic [DATA_W-1:0] nextPc,
  input logic [DATA_W-1:0] retAddr,
  input logic [DATA_W-1:0] immOut,
  input logic [DATA_W-1:0] upperImm,
  input logic [DATA_W-1:0] memAddr,
  input logic              linkEn
);
  logic [5:0] opc;
  always_comb begin
    opc = instrWord[DATA_W-1 -: 6];

    assert_ret_step_R1: assert (retAddr - curPc == DATA_W'(4))
      else $error("retAddr is not curPc+4");

    if (opc[5:2] == 4'b0001 && !brTaken)
      assert_untaken_seq_R2: assert (nextPc == retAddr)
        else $error("untaken branch left sequence");

    if (opc == 6'h02 || opc == 6'h03)
      assert_jump_region_R3: assert (nextPc[DATA_W-1 -: 4] == retAddr[DATA_W-1 -: 4]
                                     && nextPc[1:0] == 2'b00)
        else $error("jump target leaves region or is misaligned");

    assert_upper_low_zero_R6: assert (upperImm[DATA_W-IMM_W-1:0] == '0
                                      && upperImm[DATA_W-1 -: IMM_W] == instrWord[IMM_W-1:0])
      else $error("upper immediate malformed");

    assert_disp_low_R7: assert (((memAddr - regVal) & DATA_W'((1 << IMM_W) - 1))
                                == DATA_W'(instrWord[IMM_W-1:0]))
      else $error("displacement low bits differ");

    if (linkEn)
      assert_link_cause_R8: assert (opc == 6'h03 || opc == 6'h00)
        else $error("link raised for a non-call opcode");
  end
endmodule

bind npc_addrgen npc_addrgen_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
  .curPc(curPc), .instrWord(instrWord), .regVal(regVal), .brTaken(brTaken),
  .nextPc(nextPc), .retAddr(retAddr), .immOut(immOut), .upperImm(upperImm),
  .memAddr(memAddr), .linkEn(linkEn)
);

// File: tb/npc_addrgen_tb_top.sv
module npc_addrgen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] curPc = '0, instrWord = '0, regVal = '0;
  logic        brTaken = 1'b0;
  logic [31:0] nextPc, retAddr, immOut, upperImm, memAddr;
  logic        linkEn;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  npc_addrgen dut_i (
    .curPc(curPc), .instrWord(instrWord), .regVal(regVal), .brTaken(brTaken),
    .nextPc(nextPc), .retAddr(retAddr), .immOut(immOut), .upperImm(upperImm),
    .memAddr(memAddr), .linkEn(linkEn)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%08h expected=%08h (pc=%08h iw=%08h rv=%08h bt=%0b)",
               tag, act, exp, curPc, instrWord, regVal, brTaken);
    end
  endtask

  // Behavioural reference, compared at the falling edge of each cycle.
  task automatic compareAll();
    logic [31:0] seq, sx, zx, expNext, expImm;
    int op, fn;
    string pcTag;
    bit expLink;
    seq = curPc + 32'd4;
    op  = int'(instrWord[31:26]);
    fn  = int'(instrWord[5:0]);
    sx  = 32'(signed'(instrWord[15:0]));
    zx  = {16'd0, instrWord[15:0]};
    expNext = seq; pcTag = "R1 sequential";
    if (op == 0 && (fn == 8 || fn == 9)) begin
      expNext = regVal; pcTag = "R4 register jump";
    end else if (op == 2 || op == 3) begin
      expNext = (seq & 32'hF000_0000) | (instrWord[25:0] * 4); pcTag = "R3 jump splice";
    end else if (op >= 4 && op <= 7) begin
      pcTag = "R2 branch";
      if (brTaken) expNext = seq + sx * 4;
    end else if (brTaken) begin
      pcTag = "R9 brTaken ignored";
    end
    expImm  = (op >= 12 && op <= 14) ? zx : sx;
    expLink = (op == 3) || (op == 0 && fn == 9);
    chk(pcTag, nextPc, expNext);
    chk("R1 return address", retAddr, seq);
    chk("R5 immediate extension", immOut, expImm);
    chk("R6 upper immediate", upperImm, instrWord[15:0] * 32'h1_0000);
    chk("R7 displacement", memAddr, regVal + sx);
    chk("R8 link enable", {31'd0, linkEn}, {31'd0, expLink});
  endtask

  task automatic apply(logic [31:0] pc, logic [31:0] iw, logic [31:0] rv, logic bt);
    @(posedge clk);
    #1;
    curPc = pc; instrWord = iw; regVal = rv; brTaken = bt;
    @(negedge clk);
    compareAll();
  endtask

  function automatic logic [31:0] mk(int op, int rest);
    return {6'(op), 26'(rest)};
  endfunction

  initial begin
    logic [5:0] opPool [12] = '{6'h00, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06,
                                6'h07, 6'h08, 6'h0C, 6'h0E, 6'h0F, 6'h23};
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll(); // state after reset with all-zero inputs
    // R1 sequential arithmetic immediate
    apply(32'h0040_0000, mk(6'h08, 26'h0000_0004), 32'h10, 1'b0);
    // R2 taken forward and backward, untaken, and a wrap below zero
    apply(32'h0040_0100, mk(6'h04, 32'h0000_0010), 32'h0, 1'b1);
    apply(32'h0040_0100, mk(6'h05, 32'h0000_FFFC), 32'h0, 1'b1);
    apply(32'h0040_0100, mk(6'h06, 32'h0000_FFFC), 32'h0, 1'b0);
    apply(32'h0000_0008, mk(6'h07, 32'h0000_8000), 32'h0, 1'b1);
    // R9 brTaken high on non-branch opcodes
    apply(32'h0040_0200, mk(6'h0C, 32'h0000_8001), 32'h5, 1'b1);
    apply(32'h0040_0200, mk(6'h00, 32'h0000_0020), 32'h5, 1'b1);
    // R3 jump and call, including region change when PC+4 wraps
    apply(32'h1000_0040, mk(6'h02, 32'h03FF_FFFF), 32'h0, 1'b0);
    apply(32'hFFFF_FFFC, mk(6'h03, 32'h0000_1234), 32'h0, 1'b0);
    apply(32'h2FFF_FFFC, mk(6'h02, 32'h0000_0001), 32'h0, 1'b1);
    // R4 register jump and register call, R8 link
    apply(32'h0040_0300, mk(6'h00, 32'h03E0_0008), 32'h8000_1230, 1'b0);
    apply(32'h0040_0300, mk(6'h00, 32'h03E0_0009), 32'h0000_0ABC, 1'b1);
    // R5/R6/R7 lui, ori with bit 15 set, load with negative displacement
    apply(32'h0, mk(6'h0F, 32'h0000_ABCD), 32'h0, 1'b0);
    apply(32'h0, mk(6'h0D, 32'h0000_F00F), 32'h0, 1'b0);
    apply(32'h0, mk(6'h23, 32'h0000_FFF8), 32'h0000_0004, 1'b0);
    apply(32'h0, mk(6'h0E, 32'h0000_7FFF), 32'hFFFF_FFFF, 1'b0);
    // random sweep across all opcode groups
    for (int i = 0; i < 400; i++) begin
      logic [31:0] iw;
      iw = $urandom;
      iw[31:26] = opPool[$urandom_range(0, 11)];
      if (iw[31:26] == 6'h00) iw[5:0] = 6'($urandom_range(7, 10));
      apply({$urandom} & 32'hFFFF_FFFC, iw, $urandom, 1'($urandom_range(0, 1)));
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule